// File: doc/BRIEF.md
# Transmit Descriptor Prefetch Controller

This block decides when a transmit queue should pull descriptors from a circular ring in host memory into a 64-entry on-chip descriptor store. It also decides how many to pull. It keeps its own fetch pointer and a latched copy of the software tail pointer. It compares the ring distance between them with the on-chip occupancy and two programmable thresholds. When a fetch is due, it raises a request that carries a start index and a count. It holds that request until the DMA engine answers with a one-cycle completion pulse.

If the store is empty, any available descriptor triggers a fetch at once. If the store is only low, a prefetch starts only when enough descriptors wait in host memory and no higher-priority DMA is pending. Fetch counts never exceed the free space and never cross the end of the ring. When the backlog in host memory is larger than the free space, the count is trimmed so that the following fetch begins on a cache-line boundary. Otherwise the count is rounded down to whole cache lines.

Top module: `txd_prefetch_ctrl`

## Requirements
- R1: After reset `req_valid` is low and the fetch pointer is 0, so the first fetch after reset starts at index 0.
- R2: With `occupancy` equal to 0, a fetch is issued whenever at least one descriptor is available, whatever the values of `hp_pending` and `hthresh`.
- R3: With `occupancy` nonzero and at most `pthresh`, a prefetch is issued when the available count is at least `hthresh` and `hp_pending` is low.
- R4: With `occupancy` nonzero, no fetch is issued while `hp_pending` is high.
- R5: No fetch is issued when the available count is 0, when a nonzero `occupancy` exceeds `pthresh`, or when the available count is below `hthresh` with nonzero `occupancy`.
- R6: `req_count` is never 0 and never exceeds 64 minus `occupancy`. No fetch is issued when `occupancy` is 64.
- R7: When the available count exceeds the free space, the count is the largest value, no larger than the free space, that makes `req_start + req_count` a multiple of `line_desc`. If no such nonzero value exists, the count is the free space.
- R8: When the available count fits in the free space, the count is the candidate rounded down to a multiple of `line_desc`. If that gives 0, the count is the candidate itself.
- R9: `req_start + req_count` never exceeds `ring_len`. A fetch that ends at `ring_len` wraps the fetch pointer to 0.
- R10: Only one request is outstanding. `req_start` and `req_count` hold until `req_done`, and on `req_done` the fetch pointer advances by `req_count`. A `req_done` pulse with no request outstanding has no effect.
- R11: A tail write during an outstanding fetch is kept and is used to size the next fetch after completion.
- R12: `head_ld` with no request outstanding loads the fetch pointer from `head_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len | input | PTR_W | Number of descriptors in the ring |
| head_ld | input | 1 | Load the fetch pointer from head_val |
| head_val | input | PTR_W | Head index to load |
| tail_wr | input | 1 | Tail pointer write strobe |
| tail_val | input | PTR_W | New tail index, one past the last valid descriptor |
| occupancy | input | CNT_W | Descriptors currently held on chip |
| pthresh | input | CNT_W | Low-occupancy prefetch threshold |
| hthresh | input | CNT_W | Minimum host backlog for a prefetch |
| line_desc | input | CNT_W | Cache-line size in descriptors, a power of two |
| hp_pending | input | 1 | Higher-priority DMA is waiting |
| req_valid | output | 1 | Fetch request outstanding |
| req_start | output | PTR_W | First ring index of the fetch |
| req_count | output | CNT_W | Descriptors to fetch |
| req_done | input | 1 | Completion pulse from the DMA engine |

## Verification
The assertions assume that `occupancy` holds still while a request is outstanding. They also assume that `tail_val` and `head_val` are below `ring_len` and that `line_desc` is a nonzero power of two. The stimulus changes occupancy only while no request is pending or on the completion cycle. Before each pointer load it parks occupancy at 64, so that no fetch is sized from half-written settings. Each table row programs ring size, pointers and thresholds with the store full, then drops occupancy to the value under test and samples the request a few cycles later.

// File: rtl/txd_prefetch_ctrl.sv
module txd_prefetch_ctrl #(
  parameter int PTR_W     = 8,
  parameter int BUF_DEPTH = 64,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ring_len,
  input  logic             head_ld,
  input  logic [PTR_W-1:0] head_val,
  input  logic             tail_wr,
  input  logic [PTR_W-1:0] tail_val,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] pthresh,
  input  logic [CNT_W-1:0] hthresh,
  input  logic [CNT_W-1:0] line_desc,
  input  logic             hp_pending,
  output logic             req_valid,
  output logic [PTR_W-1:0] req_start,
  output logic [CNT_W-1:0] req_count,
  input  logic             req_done
);

  logic [PTR_W-1:0] fptr, tail_q;

  wire [PTR_W-1:0] avail    = (tail_q >= fptr) ? tail_q - fptr : tail_q + ring_len - fptr;
  wire [PTR_W-1:0] span     = ring_len - fptr;
  wire [PTR_W-1:0] free_sp  = PTR_W'(BUF_DEPTH) - PTR_W'(occupancy);
  wire [PTR_W-1:0] lim      = (span < free_sp) ? span : free_sp;
  wire [PTR_W-1:0] cand     = (avail < lim) ? avail : lim;
  wire [PTR_W-1:0] mask     = PTR_W'(line_desc) - PTR_W'(1);
  wire [PTR_W-1:0] end_off  = (fptr + cand) & mask;
  wire [PTR_W-1:0] trimmed  = cand - end_off;
  wire [PTR_W-1:0] rounded  = cand & ~mask;
  wire             backlog  = avail > free_sp;
  wire [PTR_W-1:0] cnt_sel  = backlog ? ((end_off != '0 && trimmed != '0) ? trimmed : cand)
                                      : ((rounded != '0) ? rounded : cand);

  wire buf_empty = (occupancy == '0);
  wire low_ok    = (occupancy <= pthresh) && (avail >= PTR_W'(hthresh)) && !hp_pending;
  wire want      = (avail != '0) && (free_sp != '0) && (buf_empty || low_ok);
  wire issue     = !req_valid && !head_ld && want;

  wire [PTR_W-1:0] next_ptr = fptr + PTR_W'(req_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fptr      <= '0;
      tail_q    <= '0;
      req_valid <= 1'b0;
      req_start <= '0;
      req_count <= '0;
    end else begin
      if (tail_wr) tail_q <= tail_val;
      if (req_valid && req_done) begin
        req_valid <= 1'b0;
        fptr      <= (next_ptr == ring_len) ? '0 : next_ptr;
      end else if (!req_valid && head_ld) begin
        fptr <= head_val;
      end else if (issue) begin
        req_valid <= 1'b1;
        req_start <= fptr;
        req_count <= CNT_W'(cnt_sel);
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !req_valid); // R1
  AST_NONZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_count != '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (PTR_W+1)'(req_count) + (PTR_W+1)'($past(occupancy)) <= (PTR_W+1)'(BUF_DEPTH)); // R6
  AST_NO_RING_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (PTR_W+1)'(req_start) + (PTR_W+1)'(req_count) <= (PTR_W+1)'(ring_len)); // R9
  AST_YIELD_HP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(occupancy) == '0 || !$past(hp_pending))); // R4
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done |=> req_valid && $stable(req_start) && $stable(req_count)); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_done |=> !req_valid); // R10

endmodule

// File: tb/tb_txd_prefetch_ctrl.sv
`timescale 1ns/1ps
module tb_txd_prefetch_ctrl;
  localparam int PTR_W = 8;
  localparam int CNT_W = 7;
  localparam int NV = 13;

  logic clk = 0, rst_n = 0;
  logic [PTR_W-1:0] ring_len = 8'd64, head_val = '0, tail_val = '0;
  logic head_ld = 0, tail_wr = 0, hp_pending = 0, req_done = 0;
  logic [CNT_W-1:0] occupancy = 7'd64, pthresh = '0, hthresh = 7'd1, line_desc = 7'd8;
  logic req_valid;
  logic [PTR_W-1:0] req_start;
  logic [CNT_W-1:0] req_count;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  txd_prefetch_ctrl dut (.clk(clk), .rst_n(rst_n), .ring_len(ring_len), .head_ld(head_ld),
    .head_val(head_val), .tail_wr(tail_wr), .tail_val(tail_val), .occupancy(occupancy),
    .pthresh(pthresh), .hthresh(hthresh), .line_desc(line_desc), .hp_pending(hp_pending),
    .req_valid(req_valid), .req_start(req_start), .req_count(req_count), .req_done(req_done));

  // ring, fptr, tail, occ, pth, hth, line, hp, fire, start, count
  localparam logic [68:0] VEC [NV] = '{
    {8'd64, 8'd0,  8'd5,  7'd0,  7'd0,  7'd8,  7'd8, 1'b1, 1'b1, 8'd0,  7'd5 },  // R2
    {8'd64, 8'd4,  8'd30, 7'd10, 7'd16, 7'd8,  7'd8, 1'b0, 1'b1, 8'd4,  7'd24},  // R3
    {8'd64, 8'd4,  8'd30, 7'd10, 7'd16, 7'd8,  7'd8, 1'b1, 1'b0, 8'd0,  7'd0 },  // R4
    {8'd64, 8'd4,  8'd30, 7'd10, 7'd16, 7'd32, 7'd8, 1'b0, 1'b0, 8'd0,  7'd0 },  // R5
    {8'd64, 8'd4,  8'd30, 7'd20, 7'd16, 7'd8,  7'd8, 1'b0, 1'b0, 8'd0,  7'd0 },  // R5
    {8'd64, 8'd3,  8'd60, 7'd44, 7'd48, 7'd8,  7'd8, 1'b0, 1'b1, 8'd3,  7'd13},  // R7
    {8'd40, 8'd32, 8'd10, 7'd0,  7'd0,  7'd8,  7'd8, 1'b0, 1'b1, 8'd32, 7'd8 },  // R9
    {8'd64, 8'd7,  8'd7,  7'd0,  7'd0,  7'd1,  7'd8, 1'b0, 1'b0, 8'd0,  7'd0 },  // R5
    {8'd64, 8'd2,  8'd20, 7'd60, 7'd63, 7'd1,  7'd4, 1'b0, 1'b1, 8'd2,  7'd2 },  // R7
    {8'd64, 8'd8,  8'd50, 7'd48, 7'd48, 7'd8,  7'd8, 1'b0, 1'b1, 8'd8,  7'd16},  // R6
    {8'd64, 8'd0,  8'd20, 7'd64, 7'd64, 7'd1,  7'd8, 1'b0, 1'b0, 8'd0,  7'd0 },  // R6
    {8'd64, 8'd0,  8'd8,  7'd16, 7'd16, 7'd8,  7'd8, 1'b0, 1'b1, 8'd0,  7'd8 },  // R3
    {8'd64, 8'd10, 8'd13, 7'd5,  7'd8,  7'd2,  7'd8, 1'b0, 1'b1, 8'd10, 7'd3 }   // R8
  };
  localparam string TAG [NV] = '{"R2","R3","R4","R5","R5","R7","R9","R5","R7","R6","R6","R3","R8"};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_fetch(logic park);
    if (park) begin occupancy = 7'd64; pthresh = '0; end
    req_done = 1; cyc(1); req_done = 0; cyc(2);
  endtask

  task automatic load(logic [7:0] rl, logic [7:0] hv, logic [7:0] tv);
    occupancy = 7'd64; pthresh = '0; hp_pending = 0;
    ring_len = rl; head_val = hv; tail_val = tv; head_ld = 1; tail_wr = 1;
    cyc(1); head_ld = 0; tail_wr = 0; cyc(1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 idle after reset", req_valid, 0);
    tail_val = 8'd3; tail_wr = 1; cyc(1); tail_wr = 0; occupancy = '0; cyc(3);
    chk("R1 first start", req_start, 0);
    chk("R1 first count", req_count, 3);
    finish_fetch(1);

    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      load(v[68:61], v[60:53], v[52:45]);
      hthresh = v[30:24]; line_desc = v[23:17]; hp_pending = v[16];
      pthresh = v[37:31]; occupancy = v[44:38];
      cyc(3);
      chk({TAG[i], " valid"}, req_valid, v[15]);
      if (v[15]) begin
        chk({TAG[i], " start (R12)"}, req_start, v[14:7]);
        chk({TAG[i], " count"}, req_count, v[6:0]);
        finish_fetch(1);
      end
    end

    load(8'd40, 8'd32, 8'd10);
    line_desc = 7'd8; occupancy = '0; cyc(3);
    chk("R9 split start", req_start, 32);
    chk("R9 split count", req_count, 8);
    finish_fetch(0); cyc(1);
    chk("R9 wrapped start", req_start, 0);
    chk("R9 wrapped count", req_count, 8);
    finish_fetch(1);

    load(8'd64, 8'd0, 8'd5);
    occupancy = '0; cyc(3);
    chk("R10 issued", req_valid, 1);
    tail_val = 8'd20; tail_wr = 1; cyc(1); tail_wr = 0; cyc(3);
    chk("R10 still valid", req_valid, 1);
    chk("R10 start held", req_start, 0);
    chk("R10 count held", req_count, 5);
    finish_fetch(0); cyc(1);
    chk("R11 next start", req_start, 5);
    chk("R11 next count", req_count, 8);
    finish_fetch(1);

    req_done = 1; cyc(1); req_done = 0; cyc(2);
    chk("R10 idle done ignored valid", req_valid, 0);
    occupancy = '0; cyc(3);
    chk("R10 idle done ignored start", req_start, 13);
    chk("R10 idle done ignored count", req_count, 7);
    finish_fetch(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule